// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Carry/Zero Flags

This block is the data path of a small 8-bit processor. Each cycle that an operation is presented, it combines a register operand `a` with a second operand `b` (taken from another register or from a literal by the caller), using the carry flag it holds itself. One cycle later it presents the result byte, the new carry and zero flags, and a write-enable. The write-enable tells the surrounding core whether the result belongs in the destination register.

The operations are add and subtract, each with or without the incoming carry. There is a compare and the three bitwise logic functions. A non-destructive bit test reports odd parity through carry. Shifts in either direction take one of four fill sources, and rotates run in either direction. Register storage, instruction decode and program flow belong to the caller. The caller decodes its instruction into the 4-bit operation code and the 2-bit fill selector.

Top module: `byte_alu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `res_data`=0, `res_valid`=0, `res_we`=0, `flag_c`=0 and `flag_z`=0.
- R2: Operation 0 (add) returns (a+b) mod 256. Operation 1 (add with carry) returns (a+b+C) mod 256. Carry is set when the sum exceeds 255, zero is set when the result byte is 0, and the write-enable is 1.
- R3: Operation 2 (subtract) returns (a-b) mod 256. Operation 3 (subtract with borrow) returns (a-b-C) mod 256. Carry is set when the true difference is negative, zero matches the result byte, and the write-enable is 1.
- R4: Operation 4 (compare) sets carry and zero exactly as operation 2 would, and holds the write-enable at 0.
- R5: Operations 5, 6 and 7 (AND, OR, XOR) return the bitwise result. They always clear carry, set zero when the result is 0, and assert the write-enable.
- R6: Operation 8 (test) forms a AND b and sets zero when that value is 0. It sets carry to 1 when that value has an odd number of one bits, and holds the write-enable at 0.
- R7: Operation 9 (shift left) moves bit 7 of a into carry and shifts every other bit up by one. The new bit 0 is chosen by `in_fill`: 0 gives a 0, 1 gives a 1, 2 gives the old bit 0, and 3 gives the old carry. Zero matches the result and the write-enable is 1.
- R8: Operation 10 (shift right) moves bit 0 of a into carry and shifts every other bit down by one. The new bit 7 is chosen by `in_fill`: 0 gives a 0, 1 gives a 1, 2 gives the old bit 7, and 3 gives the old carry. With fill 1 the zero flag is always 0.
- R9: Operations 11 (rotate left) and 12 (rotate right) move the bit that leaves one end into the other end and also into carry. Zero matches the result, `in_fill` and `b` have no effect, and the write-enable is 1.
- R10: Outputs change one clock after an edge where `in_valid` is 1, and `res_valid` is then 1. After an edge with `in_valid` 0, `res_valid` and `res_we` are 0, and both flags keep their values.
- R11: Operation codes 13 to 15 are reserved. They return `a` unchanged, keep both flags, and hold the write-enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_fill | input | 2 | Fill source for shifts |
| in_a | input | 8 | Register operand |
| in_b | input | 8 | Second operand (register or literal) |
| res_data | output | 8 | Result byte |
| res_we | output | 1 | Result should be written to the register |
| res_valid | output | 1 | Result and flags were updated by the last cycle |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The properties assume that `in_op`, `in_fill`, `in_a` and `in_b` are known, non-X values on every edge where `in_valid` is high. They also assume that reset is applied before the first operation, so that the held flags start from a defined state. The stimulus only drives these inputs at the falling edge, always with defined values. It draws every operation code, including the reserved ones, and every fill selector from a seeded random source, with idle cycles mixed in. Directed cases cover carry and borrow chains, all-ones and zero operands, and the parity extremes.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_EDGE  = 2'd2,
    FILL_CARRY = 2'd3
  } fill_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         use_cin,
  input  logic         subtract,
  output logic [W-1:0] r,
  output logic         cout
);
  localparam int SW = W + 1;
  logic [SW-1:0] ext_a, ext_b, ext_c, total;

  always_comb begin
    ext_a = {1'b0, a};
    ext_b = {1'b0, b};
    ext_c = {{W{1'b0}}, cin & use_cin};
    if (subtract) total = ext_a - ext_b - ext_c;
    else          total = ext_a + ext_b + ext_c;
    r    = total[W-1:0];
    cout = total[W];
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] r,
  output logic         odd_parity
);
  import byte_alu_pkg::*;

  always_comb begin
    case (logic_fn_e'(fn))
      LG_OR:   r = a | b;
      LG_XOR:  r = a ^ b;
      default: r = a & b;
    endcase
    odd_parity = ^r;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         to_right,
  input  logic         rotate,
  input  logic [1:0]   fill,
  output logic [W-1:0] r,
  output logic         cout
);
  import byte_alu_pkg::*;

  logic out_bit;
  logic in_bit;

  always_comb begin
    out_bit = to_right ? a[0] : a[W-1];
    if (rotate) begin
      in_bit = out_bit;
    end else begin
      case (fill_e'(fill))
        FILL_ZERO:  in_bit = 1'b0;
        FILL_ONE:   in_bit = 1'b1;
        FILL_EDGE:  in_bit = to_right ? a[W-1] : a[0];
        default:    in_bit = cin;
      endcase
    end
    if (to_right) r = {in_bit, a[W-1:1]};
    else          r = {a[W-2:0], in_bit};
    cout = out_bit;
  end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [1:0]   in_fill,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] res_data,
  output logic         res_we,
  output logic         res_valid,
  output logic         flag_c,
  output logic         flag_z
);
  import byte_alu_pkg::*;

  alu_op_e op;
  logic [W-1:0] as_r, lg_r, sh_r;
  logic as_c, lg_p, sh_c;
  logic as_sub, as_usec;
  logic [1:0] lg_fn;
  logic sh_right, sh_rot;

  logic [W-1:0] nx_r;
  logic nx_c, nx_z, nx_we;

  assign op       = alu_op_e'(in_op);
  assign as_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  assign as_usec  = (op == OP_ADDC) || (op == OP_SUBC);
  assign sh_right = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  always_comb begin
    case (op)
      OP_OR:   lg_fn = 2'(LG_OR);
      OP_XOR:  lg_fn = 2'(LG_XOR);
      default: lg_fn = 2'(LG_AND);
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(in_a), .b(in_b), .cin(flag_c), .use_cin(as_usec),
    .subtract(as_sub), .r(as_r), .cout(as_c)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a(in_a), .b(in_b), .fn(lg_fn), .r(lg_r), .odd_parity(lg_p)
  );

  alu_shifter #(.W(W)) u_shifter (
    .a(in_a), .cin(flag_c), .to_right(sh_right), .rotate(sh_rot),
    .fill(in_fill), .r(sh_r), .cout(sh_c)
  );

  always_comb begin
    nx_r  = in_a;
    nx_c  = flag_c;
    nx_we = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        nx_r = as_r; nx_c = as_c; nx_we = 1'b1;
      end
      OP_CMP: begin
        nx_r = as_r; nx_c = as_c;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nx_r = lg_r; nx_c = 1'b0; nx_we = 1'b1;
      end
      OP_TEST: begin
        nx_r = lg_r; nx_c = lg_p;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nx_r = sh_r; nx_c = sh_c; nx_we = 1'b1;
      end
      default: ;
    endcase
    if (in_op > 4'(OP_ROR)) nx_z = flag_z;
    else                    nx_z = (nx_r == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_we    <= 1'b0;
      res_valid <= 1'b0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      res_valid <= in_valid;
      res_we    <= in_valid & nx_we;
      if (in_valid) begin
        res_data <= nx_r;
        flag_c   <= nx_c;
        flag_z   <= nx_z;
      end
    end
  end
endmodule

// File: rtl/byte_alu_props.sv
module byte_alu_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [3:0]   in_op,
  input logic [1:0]   in_fill,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] res_data,
  input logic         res_we,
  input logic         res_valid,
  input logic         flag_c,
  input logic         flag_z
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_we && !flag_c && !flag_z));

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd4) |=> (res_valid && !res_we));

  p_logic_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd5 && in_op <= 4'd7) |=> !flag_c);

  p_test_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd8) |=> !res_we);

  p_fill_one_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd10 && in_fill == 2'd1) |=> (!flag_z && res_data[W-1]));

  p_rotl_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd11) |=>
      (res_data == {$past(in_a[W-2:0]), $past(in_a[W-1])} && flag_c == $past(in_a[W-1])));

  p_zero_tracks_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 4'd12) |=> (flag_z == (res_data == '0)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !res_we && $stable(flag_c) && $stable(flag_z)));

  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd13) |=> (!res_we && $stable(flag_c) && $stable(flag_z)));
endmodule

bind byte_alu_core byte_alu_props #(.W(W)) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_fill(in_fill),
  .in_a(in_a), .in_b(in_b), .res_data(res_data), .res_we(res_we),
  .res_valid(res_valid), .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/sim_byte_alu_core.sv
`timescale 1ns/1ps
module sim_byte_alu_core;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [3:0] in_op;
  logic [1:0] in_fill;
  logic [7:0] in_a, in_b;
  logic [7:0] res_data;
  logic res_we, res_valid, flag_c, flag_z;

  int checks = 0;
  int errors = 0;
  logic mc = 1'b0;
  logic mz = 1'b0;

  always #10 clk = ~clk;

  byte_alu_core #(.W(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_fill(in_fill),
    .in_a(in_a), .in_b(in_b), .res_data(res_data), .res_we(res_we),
    .res_valid(res_valid), .flag_c(flag_c), .flag_z(flag_z)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      default: return "R11";
    endcase
  endfunction

  // returns {we, c, z, r}
  function automatic logic [10:0] ref_op(input logic [3:0] op, input logic [1:0] fl,
                                         input logic [7:0] a, input logic [7:0] b,
                                         input logic c, input logic z);
    int t;
    logic [7:0] r;
    logic nc, we, f;
    r = a; nc = c; we = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        t = int'(a) + int'(b) + ((op == 4'd1) ? int'(c) : 0);
        r = t[7:0]; nc = (t > 255); we = 1'b1;
      end
      4'd2, 4'd3, 4'd4: begin
        t = int'(a) - int'(b) - ((op == 4'd3) ? int'(c) : 0);
        r = t[7:0]; nc = (t < 0); we = (op != 4'd4);
      end
      4'd5: begin r = a & b; nc = 1'b0; we = 1'b1; end
      4'd6: begin r = a | b; nc = 1'b0; we = 1'b1; end
      4'd7: begin r = a ^ b; nc = 1'b0; we = 1'b1; end
      4'd8: begin r = a & b; nc = ^(a & b); end
      4'd9: begin
        f = (fl == 2'd0) ? 1'b0 : (fl == 2'd1) ? 1'b1 : (fl == 2'd2) ? a[0] : c;
        r = {a[6:0], f}; nc = a[7]; we = 1'b1;
      end
      4'd10: begin
        f = (fl == 2'd0) ? 1'b0 : (fl == 2'd1) ? 1'b1 : (fl == 2'd2) ? a[7] : c;
        r = {f, a[7:1]}; nc = a[0]; we = 1'b1;
      end
      4'd11: begin r = {a[6:0], a[7]}; nc = a[7]; we = 1'b1; end
      4'd12: begin r = {a[0], a[7:1]}; nc = a[0]; we = 1'b1; end
      default: ;
    endcase
    return {we, nc, (op >= 4'd13) ? z : (r == 8'd0), r};
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act valid/we/c/z/data=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, check at following falling edge
  task automatic run(input logic [3:0] op, input logic [1:0] fl,
                     input logic [7:0] a, input logic [7:0] b);
    logic [10:0] e;
    e = ref_op(op, fl, a, b, mc, mz);
    in_valid = 1'b1; in_op = op; in_fill = fl; in_a = a; in_b = b;
    @(posedge clk); @(negedge clk);
    chk(tag_of(op), {res_valid, res_we, flag_c, flag_z, res_data}, {1'b1, e});
    mc = e[9]; mz = e[8];
  endtask

  task automatic idle(input int n);
    logic [7:0] hold;
    hold = res_data;
    in_valid = 1'b0;
    in_op = 4'($urandom_range(0, 15));
    in_a = 8'($urandom);
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      // R10: idle cycles keep flags and data, drop valid and write-enable
      chk("R10", {res_valid, res_we, flag_c, flag_z, res_data}, {2'b00, mc, mz, hold});
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_fill = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {res_valid, res_we, flag_c, flag_z, res_data}, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    // R2 carry chain
    run(4'd0, 2'd0, 8'hFF, 8'h01);
    run(4'd1, 2'd0, 8'h10, 8'h20);
    run(4'd1, 2'd0, 8'hFF, 8'hFF);
    // R3 borrow chain
    run(4'd2, 2'd0, 8'h00, 8'h01);
    run(4'd3, 2'd0, 8'h05, 8'h04);
    run(4'd3, 2'd0, 8'h05, 8'h05);
    // R4 compare
    run(4'd4, 2'd0, 8'h33, 8'h33);
    run(4'd4, 2'd0, 8'h10, 8'h80);
    // R5 logic
    run(4'd5, 2'd0, 8'hF0, 8'h0F);
    run(4'd6, 2'd0, 8'h00, 8'h00);
    run(4'd7, 2'd0, 8'hAA, 8'h55);
    // R6 parity extremes
    run(4'd8, 2'd0, 8'hFF, 8'h07);
    run(4'd8, 2'd0, 8'hFF, 8'hFF);
    run(4'd8, 2'd0, 8'h0F, 8'hF0);
    // R7 and R8 all fills
    for (int f = 0; f < 4; f++) begin
      run(4'd0, 2'd0, 8'h80, 8'h80);
      run(4'd9, 2'(f), 8'h81, 8'h00);
      run(4'd10, 2'(f), 8'h81, 8'h00);
      run(4'd10, 2'(f), 8'h00, 8'hFF);
    end
    // R9 rotates
    run(4'd11, 2'd3, 8'h80, 8'h12);
    run(4'd12, 2'd1, 8'h00, 8'hFF);
    // R11 reserved
    run(4'd13, 2'd0, 8'h5A, 8'h00);
    run(4'd15, 2'd2, 8'h00, 8'h11);
    idle(2);
    for (int i = 0; i < 3000; i++) begin
      run(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom));
      if ($urandom_range(0, 9) == 0) idle(1);
    end
    // R1 again: reset mid-stream
    rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", {res_valid, res_we, flag_c, flag_z, res_data}, 12'h000);
    finish_run();
  end
endmodule